// File: doc/BRIEF.md
# Power-of-Two Serial Rate Generator

This block produces the bit-rate clock for one serial channel. It divides a fixed reference, nominally 2.4576 MHz, by a power of two. The reference arrives as a one-cycle enable on the system clock. An 8-bit setting word carries a 4-bit rate code and a hold control. Code n makes the output toggle once every 2^n reference pulses, so one full output period is 2^(n+1) pulses. Code 0 gives half the reference (1.2288 MHz), code 7 gives 9600 Hz and code 14 gives the slowest rate, 75 Hz, which is a divide by 32768.

The serial core that uses this rate applies its own 1x, 16x or 64x oversampling. It is responsible for never selecting a code that is too fast for its own clock. For example, code 0 is too fast for all three oversampling modes. Code 15 is reserved: selecting it stops the output. The block gives two outputs: a 50% duty square wave, and a single-cycle pulse that marks each rising edge of that wave. Any write to the setting word restarts the division from a clean period.

Top module: `pow2_rate_gen`

## Requirements
- R1: After reset the rate code is 7, hold is off, and both rate_clk and rate_tick are low.
- R2: With rate code n (bits 3:0, values 0 to 14) and hold off, rate_clk toggles after every 2^n sampled ref_en pulses and starts low after a write. The result is a 50% duty square wave with a period of 2^(n+1) pulses.
- R3: A cycle with ref_en low and no write leaves rate_clk and the divider count unchanged.
- R4: While bit 7 of the stored setting is 1, rate_clk stays low, no rate_tick occurs and the count stays at zero. Writing bit 7 as 0 resumes counting from a fresh period.
- R5: Rate code 15 is invalid. While it is stored, rate_clk stays low and no rate_tick occurs.
- R6: rate_tick is high for exactly one cycle, and only in the cycle where rate_clk has just changed from low to high.
- R7: Every write (wr_en high) forces rate_clk low and clears the count at that clock edge. A ref_en pulse in the write cycle is not counted.
- R8: Bits 6:4 of wr_data have no effect. Only bits 3:0 (the code) and bit 7 (hold) are stored.
- R9: rate_clk and rate_tick are register outputs. They reflect a ref_en pulse at the same clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle pulse per reference clock period |
| wr_en | input | 1 | Setting word write strobe |
| wr_data | input | 8 | Setting word: bit 7 hold, bits 3:0 rate code |
| rate_clk | output | 1 | Divided square-wave rate output |
| rate_tick | output | 1 | One-cycle pulse on each rising edge of rate_clk |

## Verification
Both outputs are flops. They change at the same rising edge that samples a ref_en pulse or a write, so each stimulus has its result due exactly one edge later. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs against a model that counts the pulses it has itself driven since the last write. The expected level is bit n of that count, and the expected tick is a low-to-high change of that level. The sweep covers every code from 0 to 10 over three periods, plus code 14, sparse and irregular ref_en patterns, hold, the stop code, restarts in the middle of a period and writes with the reserved bits set. The model then checks every cycle, not only selected ones.

// File: rtl/pow2_rate_pkg.sv
package pow2_rate_pkg;

  // Half-period of the output, in reference pulses, for a rate code
  function automatic int unsigned half_period(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // A code drives the divider unless it is the all-ones stop code
  function automatic bit code_selects_rate(input int unsigned code,
                                           input int unsigned code_w);
    return code < ((32'd1 << code_w) - 1);
  endfunction

endpackage

// File: rtl/rate_cfg_reg.sv
module rate_cfg_reg #(
  parameter int unsigned             DATA_W     = 8,
  parameter int unsigned             CODE_W     = 4,
  parameter int unsigned             HOLD_BIT   = 7,
  parameter logic [CODE_W-1:0]       RESET_CODE = 4'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] cfg_code,
  output logic              cfg_hold,
  output logic              run_en
);
  import pow2_rate_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_code <= RESET_CODE;
      cfg_hold <= 1'b0;
    end else if (wr_en) begin
      cfg_code <= wr_data[CODE_W-1:0];
      cfg_hold <= wr_data[HOLD_BIT];
    end
  end

  assign run_en = !cfg_hold && code_selects_rate(32'(cfg_code), CODE_W);

endmodule

// File: rtl/pow2_divider.sv
module pow2_divider #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              phase_q,
  output logic              rise_evt
);
  localparam int unsigned NSEL = 2 ** CODE_W;

  // last_sel[g]: the count is at the final pulse of a half-period for code g
  logic [NSEL-1:0] last_sel;
  logic            half_done;

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    if (g == 0) begin : g_zero
      assign last_sel[g] = 1'b1;
    end else if (g <= CNT_W) begin : g_run
      assign last_sel[g] = &cnt_q[g-1:0];
    end else begin : g_stop
      assign last_sel[g] = 1'b0;
    end
  end

  assign half_done = ref_en && !clear && last_sel[code];
  assign rise_evt  = half_done && !phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (ref_en) begin
      if (last_sel[code]) begin
        cnt_q   <= '0;
        phase_q <= !phase_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  output logic tick_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= rise_evt;
  end
endmodule

// File: rtl/pow2_rate_gen.sv
module pow2_rate_gen #(
  parameter int unsigned       DATA_W     = 8,
  parameter int unsigned       CODE_W     = 4,
  parameter int unsigned       HOLD_BIT   = 7,
  parameter logic [CODE_W-1:0] RESET_CODE = 4'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rate_clk,
  output logic              rate_tick
);
  // Highest usable code is 2^CODE_W-2; its half-period needs that many bits
  localparam int unsigned CNT_W = 2 ** CODE_W - 2;

  logic [CODE_W-1:0] cfg_code;
  logic              cfg_hold;
  logic              run_en;
  logic              div_clear;
  logic [CNT_W-1:0]  div_cnt;
  logic              rise_evt;

  rate_cfg_reg #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .HOLD_BIT(HOLD_BIT), .RESET_CODE(RESET_CODE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_code(cfg_code), .cfg_hold(cfg_hold), .run_en(run_en)
  );

  // A write restarts the period; a held or stopped setting keeps it cleared
  assign div_clear = wr_en || !run_en;

  pow2_divider #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .clear(div_clear),
    .code(cfg_code), .cnt_q(div_cnt), .phase_q(rate_clk), .rise_evt(rise_evt)
  );

  rise_pulse u_tick (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .tick_q(rate_tick)
  );

endmodule

// File: rtl/pow2_rate_chk.sv
module pow2_rate_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned HOLD_BIT = 7,
  parameter int unsigned CNT_W    = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rate_clk,
  input logic              rate_tick,
  input logic [CODE_W-1:0] cfg_code,
  input logic              cfg_hold,
  input logic [CNT_W-1:0]  div_cnt
);
  import pow2_rate_pkg::*;

  localparam logic [CODE_W-1:0] STOP_CODE = '1;

  p_tick_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rate_tick |-> (rate_clk && !$past(rate_clk)));

  p_rise_gives_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_clk) |-> rate_tick);

  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |-> (!rate_clk && !rate_tick && div_cnt == '0));

  p_stop_code_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_code == STOP_CODE) |-> (!rate_clk && !rate_tick));

  p_write_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (div_cnt == '0 && !rate_clk));

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_en && !wr_en) |=> ($stable(rate_clk) && $stable(div_cnt)));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(div_cnt) < half_period(32'(cfg_code)));

  p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_code == $past(wr_data[CODE_W-1:0]) &&
               cfg_hold == $past(wr_data[HOLD_BIT])));

endmodule

bind pow2_rate_gen pow2_rate_chk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .HOLD_BIT(HOLD_BIT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en), .wr_data(wr_data),
  .rate_clk(rate_clk), .rate_tick(rate_tick), .cfg_code(cfg_code),
  .cfg_hold(cfg_hold), .div_cnt(div_cnt)
);

// File: tb/test_pow2_rate_gen.sv
`timescale 1ns/1ps
module test_pow2_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rate_clk, rate_tick;

  always #2 clk = ~clk;

  pow2_rate_gen i_pow2_rate_gen (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
    .wr_data(wr_data), .rate_clk(rate_clk), .rate_tick(rate_tick)
  );

  int unsigned vectors = 0, misses = 0;
  bit          done = 1'b0;
  string       req = "R1";

  // Bench model: pulses counted since the last write
  int unsigned m_code = 7, m_n = 0;
  bit          m_hold = 1'b0;
  bit          e_clk = 1'b0, e_tick = 1'b0;
  logic [7:0]  lfsr = 8'h5A;

  task automatic check();
    vectors++;
    if (rate_clk !== e_clk || rate_tick !== e_tick) begin
      misses++;
      $display("FAIL %s: clk/tick = %b/%b expected %b/%b (code %0d, pulses %0d)",
               req, rate_clk, rate_tick, e_clk, e_tick, m_code, m_n);
    end
  endtask

  task automatic step(input bit r, input bit w, input logic [7:0] d);
    bit nxt;
    check();
    ref_en = r; wr_en = w; wr_data = d;
    if (w) begin
      m_code = 32'(d[3:0]); m_hold = d[7]; m_n = 0;
    end else if (m_hold || m_code == 15) begin
      m_n = 0;
    end else if (r) begin
      m_n++;
    end
    nxt = (!m_hold && m_code != 15) ? bit'((m_n >> m_code) & 1) : 1'b0;
    e_tick = nxt && !e_clk;
    e_clk = nxt;
    @(negedge clk);
  endtask

  task automatic run(input int unsigned cycles);
    for (int unsigned i = 0; i < cycles; i++) step(1'b1, 1'b0, 8'h00);
  endtask

  task automatic put(input logic [7:0] d);
    step(1'b1, 1'b1, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then the reset code 7 runs
    req = "R1";
    check();
    run(300);

    // R2: sweep codes 0..10 over three full periods each
    req = "R2";
    for (int c = 0; c <= 10; c++) begin
      put(8'(c));
      run(3 * (32'd2 << c) + 3);
    end

    // R3: sparse and irregular reference pulses
    req = "R3";
    put(8'h03);
    for (int i = 0; i < 240; i++) step(i % 3 == 0, 1'b0, 8'h00);
    put(8'h02);
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], 1'b0, 8'h00);
    end

    // R4: hold bit set, then released
    req = "R4";
    put(8'h05); run(40);
    put(8'h85); run(120);
    put(8'h05); run(100);

    // R5: stop code, also with hold set
    req = "R5";
    put(8'h0F); run(100);
    put(8'h8F); run(20);

    // R7: restart in the middle of a period, with ref_en in the write cycle
    req = "R7";
    put(8'h04); run(23);
    put(8'h04); run(80);
    put(8'h01); run(3);
    put(8'h03); run(30);

    // R8: reserved bits set must not change behaviour
    req = "R8";
    put(8'h73); run(60);
    put(8'h7F); run(30);
    put(8'hF2); run(30);
    put(8'h12); run(30);

    // R6: tick alignment at a fast code
    req = "R6";
    put(8'h01); run(40);

    // R9: a single pulse at code 0 shows after one edge
    req = "R9";
    put(8'h00);
    step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);

    // R2: slowest code, one full period and the next rise
    req = "R2";
    put(8'h0E);
    run(32768 + 16384 + 4);

    check();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule